// File: doc/BRIEF.md
# Mailbox Channel with Merge Modes

This block is a short buffer that carries 32-bit messages between a processing element and its host. A producer writes with a push strobe and a consumer takes the oldest message with a pop strobe. The entry count and the free-slot count are driven on their own outputs, so a query about the channel's count can be answered without touching the data path.

There are three ways to push. A conditional push is refused when the buffer is full. An unconditional push is never refused. When it meets a full buffer it either replaces the newest entry or ORs its value into that entry, and a per-instance mode input picks which. This mode serves the signal-notification registers, whose configuration chooses OR accumulation or plain overwrite.

The number of entries is a parameter. Depth 4 serves an inbound mailbox. Depth 1 serves the outbound, interrupt-outbound and signal registers.

Top module: `msg_chan`

## Requirements
- R1: After reset the channel is empty: `count_o` is 0, `free_o` equals DEPTH and `pop_valid_o` is 0.
- R2: A conditional push (`push_force_i`=0) on a channel that holds DEPTH entries, with no pop in the same cycle, is refused. `push_ok_o` is 0 and the contents and count stay unchanged.
- R3: A pop on a non-empty channel presents the oldest entry on `pop_data_o` with `pop_valid_o`=1 in the same cycle. The remaining entries advance toward the head and the count drops by one at the next clock edge.
- R4: A pop on an empty channel fails: `pop_valid_o` is 0, `pop_data_o` is 0 and the count stays 0.
- R5: An unconditional push (`push_force_i`=1, `merge_mode_i`=0) into a full channel is accepted and replaces the most recently written entry. The count stays at DEPTH.
- R6: An unconditional push with `merge_mode_i`=1 into a full channel bitwise-ORs its value into the most recently written entry. On a channel that is not full, every push, whatever its kind or mode, appends at the tail and raises `push_ok_o`.
- R7: `count_o` plus `free_o` always equals DEPTH.
- R8: A push and a pop in the same cycle on a full channel both complete. The pop is taken first, the push appends (never overwrites or merges), `push_ok_o` is 1 and the count stays at DEPTH.
- R9: With DEPTH set to 1, the single entry follows the same rules. A conditional push onto a held value is refused, an overwrite push replaces the value, and a merge push ORs into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe |
| push_force_i | input | 1 | 1: unconditional push, 0: conditional push |
| merge_mode_i | input | 1 | Action of an unconditional push on a full channel: 1 OR-merge, 0 overwrite |
| push_data_i | input | WIDTH | Message to push |
| push_ok_o | output | 1 | Push accepted this cycle |
| pop_i | input | 1 | Pop strobe |
| pop_valid_o | output | 1 | Channel holds an entry; a pop this cycle succeeds |
| pop_data_o | output | WIDTH | Oldest entry, 0 when empty |
| count_o | output | $clog2(DEPTH+1) | Entries held |
| free_o | output | $clog2(DEPTH+1) | DEPTH minus entries held |

## Verification
The bench fills the channel and then applies each kind of push to the full state. A design that writes the tail index without bounds would corrupt the head or grow the count past DEPTH. A design that confuses the modes would leave the newest entry unmerged or clobber it. The same-cycle push and pop on a full channel is checked by draining the channel afterwards. A design that looks at fullness before the pop would refuse the push or overwrite the tail, and the drained order would show it. A pop on an empty channel must return zero and leave the count alone; a plain down-counter would wrap. A depth-1 instance covers the single-register case, where head and tail are the same slot and an off-by-one in the shift logic shows at once.

// File: rtl/msg_chan_pkg.sv
package msg_chan_pkg;
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_APPEND  = 2'd1,
    WR_REPLACE = 2'd2,
    WR_MERGE   = 2'd3
  } wr_act_e;
endpackage

// File: rtl/msg_chan_ctrl.sv
module msg_chan_ctrl
  import msg_chan_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          push_force_i,
  input  logic          merge_mode_i,
  input  logic          pop_i,
  output logic          pop_do_o,
  output logic          empty_o,
  output wr_act_e       act_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] free_o
);
  logic [CW-1:0] cnt_q, cnt_d, cnt_pop;
  logic          room;

  assign empty_o  = (cnt_q == '0);
  assign pop_do_o = pop_i & ~empty_o;
  // pop is applied before the push decision
  assign cnt_pop  = cnt_q - CW'(pop_do_o);
  assign room     = (cnt_pop != CW'(DEPTH));

  always_comb begin
    act_o = WR_NONE;
    if (push_i) begin
      if (room)              act_o = WR_APPEND;
      else if (push_force_i) act_o = merge_mode_i ? WR_MERGE : WR_REPLACE;
    end
  end

  assign wr_idx_o = IW'(cnt_pop);
  assign cnt_d    = cnt_pop + CW'(act_o == WR_APPEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign free_o  = CW'(DEPTH) - cnt_q;
endmodule

// File: rtl/msg_chan_store.sv
module msg_chan_store
  import msg_chan_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int WIDTH = 32,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_do_i,
  input  wr_act_e          act_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] head_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] shifted, nxt;

    if (g < DEPTH - 1) begin : g_mid
      assign shifted = pop_do_i ? slot_q[g+1] : slot_q[g];
    end else begin : g_tail
      // vacated tail slot is cleared on pop
      assign shifted = pop_do_i ? '0 : slot_q[g];
    end

    always_comb begin
      nxt = shifted;
      unique case (act_i)
        WR_APPEND:  if (wr_idx_i == IW'(g)) nxt = data_i;
        WR_REPLACE: if (g == DEPTH - 1)     nxt = data_i;
        WR_MERGE:   if (g == DEPTH - 1)     nxt = slot_q[g] | data_i;
        default:    nxt = shifted;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else         slot_q[g] <= nxt;
    end
  end

  assign head_o = slot_q[0];
endmodule

// File: rtl/msg_chan.sv
module msg_chan
  import msg_chan_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int WIDTH = 32,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             push_force_i,
  input  logic             merge_mode_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic             push_ok_o,
  input  logic             pop_i,
  output logic             pop_valid_o,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [CW-1:0]    count_o,
  output logic [CW-1:0]    free_o
);
  logic             pop_do, empty;
  wr_act_e          act;
  logic [IW-1:0]    wr_idx;
  logic [WIDTH-1:0] head;

  msg_chan_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push_i),
    .push_force_i (push_force_i),
    .merge_mode_i (merge_mode_i),
    .pop_i        (pop_i),
    .pop_do_o     (pop_do),
    .empty_o      (empty),
    .act_o        (act),
    .wr_idx_o     (wr_idx),
    .count_o      (count_o),
    .free_o       (free_o)
  );

  msg_chan_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pop_do_i (pop_do),
    .act_i    (act),
    .wr_idx_i (wr_idx),
    .data_i   (push_data_i),
    .head_o   (head)
  );

  assign push_ok_o   = (act != WR_NONE);
  assign pop_valid_o = ~empty;
  assign pop_data_o  = empty ? '0 : head;
endmodule

// File: rtl/msg_chan_chk.sv
module msg_chan_chk #(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          push_force_i,
  input logic          pop_i,
  input logic          push_ok_o,
  input logic          pop_valid_o,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] free_o
);
  logic full;
  assign full = (count_o == CW'(DEPTH));

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  p_refuse_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !push_force_i && !pop_i && full) |-> !push_ok_o);

  p_pop_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_o != '0 && !push_i) |=> (count_o == $past(count_o) - CW'(1)));

  p_empty_no_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> !pop_valid_o);

  p_full_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && push_force_i && !pop_i && full) |=> full);

  p_append_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full) |-> push_ok_o);

  p_sum_depth_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(count_o + free_o) == CW'(DEPTH));

  p_both_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && full) |-> push_ok_o);
endmodule

bind msg_chan msg_chan_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .push_force_i (push_force_i),
  .pop_i        (pop_i),
  .push_ok_o    (push_ok_o),
  .pop_valid_o  (pop_valid_o),
  .count_o      (count_o),
  .free_o       (free_o)
);

// File: tb/msg_chan_bench.sv
`timescale 1ns/1ps
module msg_chan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // depth-4 instance
  logic        push = 0, force_p = 0, mode = 0, pop = 0;
  logic [31:0] data = '0;
  logic        push_ok, pop_valid;
  logic [31:0] pop_data;
  logic [2:0]  count, free;
  logic        s_ok, s_pv;
  logic [31:0] s_pd;

  msg_chan #(.DEPTH(4), .WIDTH(32)) u_msg_chan (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_force_i(force_p),
    .merge_mode_i(mode), .push_data_i(data), .push_ok_o(push_ok),
    .pop_i(pop), .pop_valid_o(pop_valid), .pop_data_o(pop_data),
    .count_o(count), .free_o(free));

  // depth-1 instance
  logic        push1 = 0, force1 = 0, mode1 = 0, pop1 = 0;
  logic [31:0] data1 = '0;
  logic        push_ok1, pop_valid1;
  logic [31:0] pop_data1;
  logic        count1, free1;
  logic        s_ok1, s_pv1;
  logic [31:0] s_pd1;

  msg_chan #(.DEPTH(1), .WIDTH(32)) u_msg_chan_d1 (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push1), .push_force_i(force1),
    .merge_mode_i(mode1), .push_data_i(data1), .push_ok_o(push_ok1),
    .pop_i(pop1), .pop_valid_o(pop_valid1), .pop_data_o(pop_data1),
    .count_o(count1), .free_o(free1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one cycle on the depth-4 channel; comb responses sampled before the edge
  task automatic cyc(input logic p, input logic f, input logic m,
                     input logic [31:0] d, input logic pp);
    push = p; force_p = f; mode = m; data = d; pop = pp;
    #1;
    s_ok = push_ok; s_pv = pop_valid; s_pd = pop_data;
    @(posedge clk); @(negedge clk);
    push = 0; force_p = 0; mode = 0; pop = 0; data = '0;
  endtask

  task automatic cyc1(input logic p, input logic f, input logic m,
                      input logic [31:0] d, input logic pp);
    push1 = p; force1 = f; mode1 = m; data1 = d; pop1 = pp;
    #1;
    s_ok1 = push_ok1; s_pv1 = pop_valid1; s_pd1 = pop_data1;
    @(posedge clk); @(negedge clk);
    push1 = 0; force1 = 0; mode1 = 0; pop1 = 0; data1 = '0;
  endtask

  task automatic fill4(input logic [31:0] a, b, c, d);
    cyc(1, 0, 0, a, 0); cyc(1, 0, 0, b, 0);
    cyc(1, 0, 0, c, 0); cyc(1, 0, 0, d, 0);
  endtask

  task automatic drain_expect(input string req, input logic [31:0] a, b, c, d);
    cyc(0, 0, 0, 0, 1); check(req, s_pd, a);
    cyc(0, 0, 0, 0, 1); check(req, s_pd, b);
    cyc(0, 0, 0, 0, 1); check(req, s_pd, c);
    cyc(0, 0, 0, 0, 1); check(req, s_pd, d);
    check(req, 32'(count), 0);
  endtask

  task automatic t_reset;
    check("R1", 32'(count), 0);
    check("R1", 32'(free), 4);
    check("R1", 32'(pop_valid), 0);
    check("R7", 32'(free1), 1);
  endtask

  task automatic t_refuse;
    fill4(32'hA1, 32'hB2, 32'hC3, 32'hD4);
    check("R2", 32'(count), 4);
    check("R7", 32'(free), 0);
    cyc(1, 0, 0, 32'hEEEE, 0);
    check("R2", 32'(s_ok), 0);
    check("R2", 32'(count), 4);
    drain_expect("R2", 32'hA1, 32'hB2, 32'hC3, 32'hD4);
  endtask

  task automatic t_order;
    cyc(1, 0, 0, 32'h11, 0); cyc(1, 0, 0, 32'h22, 0); cyc(1, 0, 0, 32'h33, 0);
    check("R7", 32'(free), 1);
    cyc(0, 0, 0, 0, 1);
    check("R3", 32'(s_pv), 1);
    check("R3", s_pd, 32'h11);
    check("R3", 32'(count), 2);
    cyc(0, 0, 0, 0, 1); check("R3", s_pd, 32'h22);
    // pop and push together on a partly filled channel
    cyc(1, 0, 0, 32'h44, 1); check("R3", s_pd, 32'h33);
    check("R3", 32'(count), 1);
    cyc(0, 0, 0, 0, 1); check("R3", s_pd, 32'h44);
    check("R3", 32'(count), 0);
  endtask

  task automatic t_pop_empty;
    cyc(0, 0, 0, 0, 1);
    check("R4", 32'(s_pv), 0);
    check("R4", s_pd, 0);
    check("R4", 32'(count), 0);
    check("R4", 32'(free), 4);
  endtask

  task automatic t_overwrite;
    fill4(32'h1, 32'h2, 32'h3, 32'h4);
    cyc(1, 1, 0, 32'hF0, 0);
    check("R5", 32'(s_ok), 1);
    check("R5", 32'(count), 4);
    drain_expect("R5", 32'h1, 32'h2, 32'h3, 32'hF0);
  endtask

  task automatic t_merge;
    fill4(32'h5, 32'h6, 32'h7, 32'h0F00);
    cyc(1, 1, 1, 32'h00F0, 0);
    check("R6", 32'(s_ok), 1);
    check("R6", 32'(count), 4);
    drain_expect("R6", 32'h5, 32'h6, 32'h7, 32'h0FF0);
    // not full: merge and overwrite pushes append
    cyc(1, 0, 0, 32'h8, 0);
    cyc(1, 1, 1, 32'h9, 0);
    check("R6", 32'(s_ok), 1);
    cyc(1, 1, 0, 32'hA, 0);
    check("R6", 32'(count), 3);
    cyc(1, 0, 0, 32'hB, 0);
    drain_expect("R6", 32'h8, 32'h9, 32'hA, 32'hB);
  endtask

  task automatic t_both_full;
    fill4(32'h21, 32'h22, 32'h23, 32'h24);
    cyc(1, 0, 0, 32'h25, 1);
    check("R8", 32'(s_ok), 1);
    check("R8", s_pd, 32'h21);
    check("R8", 32'(count), 4);
    cyc(1, 1, 1, 32'h26, 1);
    check("R8", s_pd, 32'h22);
    drain_expect("R8", 32'h23, 32'h24, 32'h25, 32'h26);
  endtask

  task automatic t_depth1;
    cyc1(1, 0, 0, 32'h11, 0);
    check("R9", 32'(count1), 1);
    check("R9", 32'(free1), 0);
    cyc1(1, 0, 0, 32'h99, 0);
    check("R9", 32'(s_ok1), 0);
    cyc1(1, 1, 0, 32'h22, 0);
    check("R9", 32'(s_ok1), 1);
    cyc1(0, 0, 0, 0, 1);
    check("R9", s_pd1, 32'h22);
    check("R9", 32'(count1), 0);
    cyc1(1, 1, 1, 32'h30, 0);
    cyc1(1, 1, 1, 32'h03, 0);
    cyc1(0, 0, 0, 0, 1);
    check("R9", s_pd1, 32'h33);
    cyc1(0, 0, 0, 0, 1);
    check("R9", 32'(s_pv1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_refuse();
    t_order();
    t_pop_empty();
    t_overwrite();
    t_merge();
    t_both_full();
    t_depth1();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule